// File: doc/BRIEF.md
# Dual-Clock Mixed-Width Dual-Port RAM

This block is a simple dual-port memory for moving data between two unrelated clock domains when the producer and the consumer use different word sizes. One port writes on its own clock and the other port reads on a second, independent clock. Both ports share one storage array of fixed bit capacity. One side is the wide side and the other is the narrow side, and either side can be the wide one. The wide width is a power-of-two multiple of the narrow width, from 1 to 8.

A narrow address selects a lane inside a wide word. The word index is the narrow address divided by the ratio, and the lane is the narrow address modulo the ratio. Lane 0 holds the least significant bits of its word. The storage is a single array of wide words that the write clock writes and the read clock reads, which keeps it in a form that block RAM can take. Read data is registered once inside the array. A parameter adds a second output register.

An illegal width ratio stops elaboration. The write domain has no reset. The read domain has a synchronous active-high reset, and it clears only the read registers.

Top module: `xclk_mixed_ram`

## Requirements
- R1: Storage changes on a rising edge of `clk_a` only when `en_a` and `we_a` are both high at that edge. With either one low, a later read of the same location returns the old data.
- R2: When `en_b` is low at a rising edge of `clk_b`, the read path captures nothing. `dout_b` keeps the value of its last completed read, whatever `addr_b` does.
- R3: A read sampled at a rising edge of `clk_b` with `en_b` high shows on `dout_b` after that edge when `OUT_REG` = 0. When `OUT_REG` = 1 it shows one `clk_b` edge later, and in between `dout_b` still holds the previous result.
- R4: Both ports see the same total number of bits. The wide port has log2(ratio) fewer address bits than the narrow port. When the write side is narrow, narrow address n lands in wide word n/ratio, in bits [(n mod ratio)*narrow_width +: narrow_width].
- R5: When the read side is narrow, reading narrow address n returns bits [(n mod ratio)*narrow_width +: narrow_width] of wide word n/ratio. Lane 0 is the least significant lane.
- R6: A narrow write changes only its own lane of the addressed wide word. The other lanes of that word keep their contents.
- R7: `rst_b` high at a rising edge of `clk_b` clears `dout_b` to zero on that edge for `OUT_REG` = 0. For `OUT_REG` = 1 the output is zero by the following edge. Stored data is not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Write-port clock |
| en_a | input | 1 | Write-port enable |
| we_a | input | 1 | Write enable, effective only with `en_a` |
| addr_a | input | WR_AW | Write address in units of the write width |
| din_a | input | WR_W | Write data |
| clk_b | input | 1 | Read-port clock, unrelated to `clk_a` |
| rst_b | input | 1 | Synchronous active-high reset of the read registers |
| en_b | input | 1 | Read enable |
| addr_b | input | RD_AW (derived) | Read address in units of the read width |
| dout_b | output | RD_W | Registered read data |

## Verification
The bench builds two copies of the block side by side. The first has a 32-bit write port and an 8-bit read port, 16 wide words, with the second output register. The second has an 8-bit write port and a 32-bit read port over the same capacity, without the second register. These small depths let every one of the 64 narrow locations and all 16 wide words be written and read back in both ratio directions. The two copies also cover both read latencies, lane replacement in a single wide word, gated writes, output hold while `addr_b` moves, and a mid-run reset with storage intact, all with write and read clocks of unrelated periods.

// File: rtl/xmr_pkg.sv
package xmr_pkg;

  // ceiling log2 for small positive values
  function automatic int log2c(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  // only power-of-two ratios up to eight are supported
  function automatic bit ratio_ok(input int wide_w, input int narrow_w);
    int r;
    if (narrow_w <= 0 || (wide_w % narrow_w) != 0) return 1'b0;
    r = wide_w / narrow_w;
    return (r == 1) || (r == 2) || (r == 4) || (r == 8);
  endfunction

endpackage

// File: rtl/xmr_wr_port.sv
// Write-side address decode: turns a write-width access into a wide-word
// index, a lane select vector and lane-replicated data.
module xmr_wr_port #(
  parameter int WR_W    = 32,
  parameter int WIDE_W  = 32,
  parameter int RATIO   = 4,
  parameter int WR_AW   = 8,
  parameter int WORD_AW = 8
) (
  input  logic               en,
  input  logic               we,
  input  logic [WR_AW-1:0]   addr,
  input  logic [WR_W-1:0]    din,
  output logic               go,
  output logic [WORD_AW-1:0] word,
  output logic [RATIO-1:0]   lanes,
  output logic [WIDE_W-1:0]  data
);

  localparam int LANE_AW = WR_AW - WORD_AW;

  assign go = en & we;

  generate
    if (LANE_AW > 0) begin : g_narrow
      logic [LANE_AW-1:0] lane;
      assign word  = addr[WR_AW-1:LANE_AW];
      assign lane  = addr[LANE_AW-1:0];
      assign lanes = RATIO'(1) << lane;
      assign data  = {RATIO{din}};
    end else begin : g_wide
      assign word  = addr;
      assign lanes = '1;
      assign data  = din;
    end
  endgenerate

endmodule

// File: rtl/xmr_storage.sv
// Wide-word storage array: lane-enabled writes on clk_a, registered
// reads on clk_b. Kept in a shape that maps onto block RAM.
module xmr_storage #(
  parameter int WIDE_W  = 32,
  parameter int LANE_W  = 8,
  parameter int RATIO   = 4,
  parameter int WORD_AW = 8
) (
  input  logic               clk_a,
  input  logic               wr_go,
  input  logic [WORD_AW-1:0] wr_word,
  input  logic [RATIO-1:0]   wr_lanes,
  input  logic [WIDE_W-1:0]  wr_data,
  input  logic               clk_b,
  input  logic               rst_b,
  input  logic               rd_en,
  input  logic [WORD_AW-1:0] rd_word,
  output logic [WIDE_W-1:0]  rd_q
);

  localparam int WORDS = 1 << WORD_AW;

  logic [WIDE_W-1:0] mem [WORDS];

  always_ff @(posedge clk_a) begin
    if (wr_go) begin
      for (int l = 0; l < RATIO; l++) begin
        if (wr_lanes[l]) mem[wr_word][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk_b) begin
    if (rst_b)      rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_word];
  end

endmodule

// File: rtl/xmr_rd_port.sv
// Read-side decode and output stage: word index to the array, lane
// selection on the returned wide word, optional second output register.
module xmr_rd_port #(
  parameter int RD_W    = 8,
  parameter int WIDE_W  = 32,
  parameter int RD_AW   = 10,
  parameter int WORD_AW = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [RD_AW-1:0]   addr,
  output logic [WORD_AW-1:0] rd_word,
  input  logic [WIDE_W-1:0]  rd_q,
  output logic [RD_W-1:0]    dout
);

  localparam int LANE_AW = RD_AW - WORD_AW;

  logic [RD_W-1:0] sel;

  generate
    if (LANE_AW > 0) begin : g_narrow
      logic [LANE_AW-1:0] lane_q;
      assign rd_word = addr[RD_AW-1:LANE_AW];
      always_ff @(posedge clk) begin
        if (rst)     lane_q <= '0;
        else if (en) lane_q <= addr[LANE_AW-1:0];
      end
      assign sel = rd_q[lane_q*RD_W +: RD_W];
    end else begin : g_wide
      assign rd_word = addr;
      assign sel     = rd_q;
    end

    if (OUT_REG) begin : g_two_stage
      logic            en_q;
      logic [RD_W-1:0] dout_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          en_q   <= 1'b0;
          dout_q <= '0;
        end else begin
          en_q <= en;
          if (en_q) dout_q <= sel;
        end
      end
      assign dout = dout_q;
    end else begin : g_one_stage
      assign dout = sel;
    end
  endgenerate

endmodule

// File: rtl/xclk_mixed_ram.sv
module xclk_mixed_ram #(
  parameter int WR_W    = 32,
  parameter int RD_W    = 8,
  parameter int WR_AW   = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int WIDE_W    = (WR_W > RD_W) ? WR_W : RD_W,
  localparam int NAR_W     = (WR_W > RD_W) ? RD_W : WR_W,
  localparam int RATIO     = WIDE_W / NAR_W,
  localparam int LANE_AW   = xmr_pkg::log2c(RATIO),
  localparam bit WR_NARROW = (WR_W < RD_W),
  localparam bit RD_NARROW = (RD_W < WR_W),
  localparam int WORD_AW   = WR_NARROW ? (WR_AW - LANE_AW) : WR_AW,
  localparam int RD_AW     = RD_NARROW ? (WORD_AW + LANE_AW) : WORD_AW
) (
  input  logic             clk_a,
  input  logic             en_a,
  input  logic             we_a,
  input  logic [WR_AW-1:0] addr_a,
  input  logic [WR_W-1:0]  din_a,
  input  logic             clk_b,
  input  logic             rst_b,
  input  logic             en_b,
  input  logic [RD_AW-1:0] addr_b,
  output logic [RD_W-1:0]  dout_b
);

  generate
    if (!xmr_pkg::ratio_ok(WIDE_W, NAR_W)) begin : g_bad_ratio
      $error("xclk_mixed_ram: port width ratio must be 1, 2, 4 or 8");
    end
  endgenerate

  logic               wr_go;
  logic [WORD_AW-1:0] wr_word;
  logic [RATIO-1:0]   wr_lanes;
  logic [WIDE_W-1:0]  wr_data;
  logic [WORD_AW-1:0] rd_word;
  logic [WIDE_W-1:0]  rd_q;

  xmr_wr_port #(
    .WR_W(WR_W), .WIDE_W(WIDE_W), .RATIO(RATIO), .WR_AW(WR_AW), .WORD_AW(WORD_AW)
  ) u_wr (
    .en(en_a), .we(we_a), .addr(addr_a), .din(din_a),
    .go(wr_go), .word(wr_word), .lanes(wr_lanes), .data(wr_data)
  );

  xmr_storage #(
    .WIDE_W(WIDE_W), .LANE_W(NAR_W), .RATIO(RATIO), .WORD_AW(WORD_AW)
  ) u_store (
    .clk_a(clk_a), .wr_go(wr_go), .wr_word(wr_word), .wr_lanes(wr_lanes), .wr_data(wr_data),
    .clk_b(clk_b), .rst_b(rst_b), .rd_en(en_b), .rd_word(rd_word), .rd_q(rd_q)
  );

  xmr_rd_port #(
    .RD_W(RD_W), .WIDE_W(WIDE_W), .RD_AW(RD_AW), .WORD_AW(WORD_AW), .OUT_REG(OUT_REG)
  ) u_rd (
    .clk(clk_b), .rst(rst_b), .en(en_b), .addr(addr_b),
    .rd_word(rd_word), .rd_q(rd_q), .dout(dout_b)
  );

endmodule

// File: rtl/xmr_checker.sv
module xmr_checker #(
  parameter int RATIO     = 4,
  parameter bit WR_NARROW = 1'b0,
  parameter int RD_W      = 8
) (
  input logic             clk_a,
  input logic             clk_b,
  input logic             rst_b,
  input logic             en_a,
  input logic             we_a,
  input logic             en_b,
  input logic             wr_go,
  input logic [RATIO-1:0] wr_lanes,
  input logic [RD_W-1:0]  dout_b
);

  // R1: the array write strobe only fires for an enabled write
  assert_wr_gate_R1: assert property (@(posedge clk_a) disable iff (rst_b)
    !(en_a && we_a) |-> !wr_go);

  // R6: a narrow write touches exactly one lane, a wide write all lanes
  assert_lanes_R6: assert property (@(posedge clk_a) disable iff (rst_b)
    wr_go |-> ($countones(wr_lanes) == (WR_NARROW ? 1 : RATIO)));

  // R2: two idle read cycles in a row leave the output untouched
  assert_hold_R2: assert property (@(posedge clk_b) disable iff (rst_b)
    (!en_b && !$past(en_b)) |=> $stable(dout_b));

  // R7: reset drives the read output to zero by the next edge
  assert_reset_R7: assert property (@(posedge clk_b)
    rst_b |=> (dout_b == '0));

endmodule

bind xclk_mixed_ram xmr_checker #(
  .RATIO(RATIO), .WR_NARROW(WR_NARROW), .RD_W(RD_W)
) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_b(rst_b), .en_a(en_a), .we_a(we_a),
  .en_b(en_b), .wr_go(wr_go), .wr_lanes(wr_lanes), .dout_b(dout_b)
);

// File: tb/xclk_mixed_ram_test.sv
`timescale 1ns/1ps
module xclk_mixed_ram_test;

  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_b = 1'b1;

  always #(CLK_A_PERIOD / 2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD / 2) clk_b = ~clk_b;

  // instance uut: 32-bit write, 8-bit read, two-stage read
  logic       en_a0 = 0, we_a0 = 0;
  logic [3:0] addr_a0 = '0;
  logic [31:0] din_a0 = '0;
  logic       en_b0 = 0;
  logic [5:0] addr_b0 = '0;
  logic [7:0] dout_b0;

  // instance uut_n: 8-bit write, 32-bit read, single-stage read
  logic       en_a1 = 0, we_a1 = 0;
  logic [5:0] addr_a1 = '0;
  logic [7:0] din_a1 = '0;
  logic       en_b1 = 0;
  logic [3:0] addr_b1 = '0;
  logic [31:0] dout_b1;

  xclk_mixed_ram #(.WR_W(32), .RD_W(8), .WR_AW(4), .OUT_REG(1'b1)) uut (
    .clk_a(clk_a), .en_a(en_a0), .we_a(we_a0), .addr_a(addr_a0), .din_a(din_a0),
    .clk_b(clk_b), .rst_b(rst_b), .en_b(en_b0), .addr_b(addr_b0), .dout_b(dout_b0)
  );

  xclk_mixed_ram #(.WR_W(8), .RD_W(32), .WR_AW(6), .OUT_REG(1'b0)) uut_n (
    .clk_a(clk_a), .en_a(en_a1), .we_a(we_a1), .addr_a(addr_a1), .din_a(din_a1),
    .clk_b(clk_b), .rst_b(rst_b), .en_b(en_b1), .addr_b(addr_b1), .dout_b(dout_b1)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [7:0] pat0(input int i);
    return 8'((i * 37 + 11) ^ 'h5A);
  endfunction

  function automatic logic [7:0] pat1(input int i);
    return 8'(i * 73 + 5);
  endfunction

  // wide word w as four narrow lanes, lane 0 in the low byte (R4, R5)
  function automatic logic [31:0] wide0(input int w);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = pat0(4 * w + l);
    return r;
  endfunction

  function automatic logic [31:0] wide1(input int w);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = pat1(4 * w + l);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr0(input int a, input logic [31:0] d, input logic en, input logic we);
    @(negedge clk_a);
    en_a0 = en; we_a0 = we; addr_a0 = 4'(a); din_a0 = d;
    @(negedge clk_a);
    en_a0 = 1'b0; we_a0 = 1'b0;
  endtask

  task automatic wr1(input int a, input logic [7:0] d);
    @(negedge clk_a);
    en_a1 = 1'b1; we_a1 = 1'b1; addr_a1 = 6'(a); din_a1 = d;
    @(negedge clk_a);
    en_a1 = 1'b0; we_a1 = 1'b0;
  endtask

  // let the last write age past two read-clock cycles
  task automatic settle();
    repeat (2) @(negedge clk_a);
    repeat (3) @(negedge clk_b);
  endtask

  // two-stage read: early = value one edge after capture, q = final value
  task automatic rd0(input int a, output logic [7:0] q, output logic [7:0] early);
    @(negedge clk_b);
    en_b0 = 1'b1; addr_b0 = 6'(a);
    @(negedge clk_b);
    en_b0 = 1'b0;
    early = dout_b0;
    @(negedge clk_b);
    q = dout_b0;
  endtask

  task automatic rd1(input int a, output logic [31:0] q);
    @(negedge clk_b);
    en_b1 = 1'b1; addr_b1 = 4'(a);
    @(negedge clk_b);
    en_b1 = 1'b0;
    q = dout_b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_a);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0]  q8, e8, prev;
    logic [31:0] q32, exp32;

    repeat (4) @(negedge clk_b);
    chk("R7 reset uut", 32'(dout_b0), 32'h0);
    chk("R7 reset uut_n", dout_b1, 32'h0);
    rst_b = 1'b0;

    for (int w = 0; w < 16; w++) wr0(w, wide0(w), 1'b1, 1'b1);
    for (int i = 0; i < 64; i++) wr1(i, pat1(i));
    settle();

    // narrow read sweep over all 64 lanes, two-cycle latency
    prev = 8'h00;
    for (int i = 0; i < 64; i++) begin
      rd0(i, q8, e8);
      chk("R5 narrow read", 32'(q8), 32'(pat0(i)));
      chk("R3 two-stage latency", 32'(e8), 32'(prev));
      prev = q8;
    end

    // wide read sweep over narrow-written data, one-cycle latency (R3)
    for (int w = 0; w < 16; w++) begin
      rd1(w, q32);
      chk("R4 narrow-write packing", q32, wide1(w));
    end

    // R6: replace lane 2 of word 5
    wr1(22, 8'hEE);
    settle();
    rd1(5, q32);
    exp32 = wide1(5);
    exp32[23:16] = 8'hEE;
    chk("R6 lane isolation", q32, exp32);

    // R1: gated writes must not land
    wr0(3, 32'hDEADBEEF, 1'b1, 1'b0);
    wr0(3, 32'h0BADF00D, 1'b0, 1'b1);
    settle();
    for (int i = 12; i < 16; i++) begin
      rd0(i, q8, e8);
      chk("R1 gated write ignored", 32'(q8), 32'(pat0(i)));
    end
    wr0(3, 32'hCAFEF00D, 1'b1, 1'b1);
    settle();
    rd0(13, q8, e8);
    chk("R1 enabled write", 32'(q8), 32'hF0);

    // R2: hold while address moves with enable low
    rd0(40, q8, e8);
    rd1(7, q32);
    @(negedge clk_b);
    addr_b0 = 6'd41; addr_b1 = 4'd8;
    repeat (4) @(negedge clk_b);
    chk("R2 hold uut", 32'(dout_b0), 32'(pat0(40)));
    chk("R2 hold uut_n", dout_b1, wide1(7));

    // R7: mid-run reset clears outputs, leaves storage
    @(negedge clk_b);
    rst_b = 1'b1;
    @(negedge clk_b);
    rst_b = 1'b0;
    @(negedge clk_b);
    chk("R7 mid reset uut", 32'(dout_b0), 32'h0);
    chk("R7 mid reset uut_n", dout_b1, 32'h0);
    rd0(40, q8, e8);
    chk("R7 storage kept", 32'(q8), 32'(pat0(40)));
    rd1(9, q32);
    chk("R7 storage kept wide", q32, wide1(9));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule